// File: doc/BRIEF.md
# Vertical Coil Link Word Serializer

This block is the digital controller for one shared coil transceiver. The coil joins two vertically stacked dies. On the network side it accepts 35-bit words through a valid/ready handshake and sends each word as a serial bit stream. A strobe travels beside the data line and toggles once per bit, so the receiving die needs no common clock. The same port can instead rebuild 35-bit words from an incoming data bit and its strobe, and hand them to the network side.

The port is in one of three modes at a time: sending, receiving or idle. A control input selects the mode. The fast serial bit clock is modelled as the block clock, and `word_tick` is a one-cycle pulse that marks the slower network word rate. A mode request is registered, so it takes effect one cycle later. A request made while a word is in motion waits until that word has finished, so a word is never cut in half.

Top module: `coil_link_top`

## Requirements
- R1: `mode_sel` codes are 2'b00 idle, 2'b01 send and 2'b10 receive. Code 2'b11 is ignored, and `mode_o` keeps its value.
- R2: A legal request that is allowed to proceed appears on `mode_o` at the first clock edge that samples it, so it is visible one cycle later.
- R3: A mode request is held back while any of these is true: a send word is in flight, a send word is being accepted, or a receive word is partly gathered (this includes the cycle of its first strobe transition).
- R4: `tx_ready` is high only when the mode is send, `word_tick` is high and no word is in flight. A word is taken when `tx_valid` and `tx_ready` are both high.
- R5: An accepted word appears on `link_dat_o` least significant bit first, one bit per cycle, for 35 cycles. The first bit appears in the cycle after acceptance.
- R6: `link_stb_o` toggles once with every transmitted bit. Between words it keeps its level, and `link_dat_o` is low.
- R7: When the mode is not send, `link_dat_o` and `link_stb_o` are both low.
- R8: In receive mode, every transition of `link_stb_i` captures `link_dat_i`. The first captured bit becomes bit 0, and 35 captures form one word on `rx_word`.
- R9: Outside receive mode, strobe and data inputs are ignored, so they cannot shift the alignment of a later word.
- R10: `rx_valid` rises in the cycle after the 35th capture. It stays high until the word is taken (`rx_ready` high) or until the next `word_tick` ends the window.
- R11: If a word completes while the previous word was never taken, `rx_ovf` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested mode code |
| mode_o | output | 2 | Mode currently in effect |
| word_tick | input | 1 | Word-rate enable pulse |
| tx_valid | input | 1 | Send word offered |
| tx_ready | output | 1 | Send word can be taken this cycle |
| tx_word | input | 35 | Word to send |
| link_dat_o | output | 1 | Serial data toward the coil |
| link_stb_o | output | 1 | Forwarded strobe toward the coil |
| link_dat_i | input | 1 | Serial data from the coil |
| link_stb_i | input | 1 | Forwarded strobe from the coil |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Network side takes the received word |
| rx_word | output | 35 | Received word |
| rx_ovf | output | 1 | Sticky loss flag |

## Verification
A wrong bit counter shows up as an early or late drop of the busy state. The strobe then toggles a different number of times, or `tx_ready` returns in the wrong cycle, and both are visible within one word time. A wrong receive count or a strobe edge captured in the wrong mode misaligns `rx_word` at the next completion. A wrong pending flag moves `rx_valid` or `rx_ovf` by a whole word. A mode change that is not properly held back shows on `mode_o` in the very next cycle.

// File: rtl/coil_link_pkg.sv
package coil_link_pkg;

  typedef enum logic [1:0] {
    LM_IDLE = 2'b00,
    LM_SEND = 2'b01,
    LM_RECV = 2'b10
  } link_mode_e;

  // Only three of the four codes name a mode.
  function automatic logic mode_code_legal(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  // A mode switch may go ahead only when no word is moving.
  function automatic logic mode_may_switch(input logic tx_moving, input logic rx_moving);
    return !(tx_moving || rx_moving);
  endfunction

endpackage

// File: rtl/coil_mode_ctl.sv
module coil_mode_ctl
  import coil_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       tx_moving,
  input  logic       rx_moving,
  output link_mode_e mode_q
);

  logic do_switch;

  always_comb begin
    do_switch = mode_code_legal(mode_sel) && mode_may_switch(tx_moving, rx_moving);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= LM_IDLE;
    else if (do_switch) mode_q <= link_mode_e'(mode_sel);
  end

endmodule

// File: rtl/coil_tx_shift.sv
module coil_tx_shift #(
  parameter int WORD_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_mode,
  input  logic              word_tick,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_ready,
  output logic              ser_dat,
  output logic              ser_stb,
  output logic              busy,
  output logic              accept
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dat_q, stb_q, busy_q;

  assign tx_ready = en_mode && word_tick && !busy_q;
  assign accept   = tx_valid && tx_ready;
  assign busy     = busy_q;
  assign ser_dat  = dat_q && en_mode;
  assign ser_stb  = stb_q && en_mode;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_mode) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      dat_q  <= 1'b0;
      stb_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (accept) begin
      dat_q  <= tx_word[0];
      sh_q   <= tx_word >> 1;
      stb_q  <= ~stb_q;
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        dat_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        dat_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
        stb_q <= ~stb_q;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/coil_rx_deshift.sv
module coil_rx_deshift #(
  parameter int WORD_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_mode,
  input  logic              ser_dat,
  input  logic              ser_stb,
  input  logic              word_tick,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_ovf,
  output logic              moving,
  output logic              done
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FINAL = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc_q, word_q, assembled;
  logic [CNT_W-1:0]  cnt_q;
  logic              prev_q, pend_q, win_q, ovf_q;
  logic              edge_w, take_w;

  assign edge_w    = en_mode && (ser_stb != prev_q);
  assign done      = edge_w && (cnt_q == FINAL);
  assign assembled = {ser_dat, acc_q[WORD_W-1:1]};
  assign rx_valid  = pend_q && win_q;
  assign take_w    = rx_valid && rx_ready;
  assign moving    = edge_w || (cnt_q != '0);
  assign rx_word   = word_q;
  assign rx_ovf    = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      win_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      prev_q <= ser_stb;
      if (edge_w) begin
        acc_q <= assembled;
        cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
      end
      if (done) begin
        word_q <= assembled;
        pend_q <= 1'b1;
        win_q  <= 1'b1;
        if (pend_q && !take_w) ovf_q <= 1'b1;
      end else begin
        if (take_w)             pend_q <= 1'b0;
        if (word_tick && win_q) win_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/coil_link_top.sv
module coil_link_top
  import coil_link_pkg::*;
#(
  parameter int WORD_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  output logic [1:0]        mode_o,
  input  logic              word_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_word,
  output logic              link_dat_o,
  output logic              link_stb_o,
  input  logic              link_dat_i,
  input  logic              link_stb_i,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_ovf
);

  link_mode_e mode_w;
  logic       tx_busy_w, tx_accept_w, rx_mid_w, rx_done_w;
  logic       send_en_w, recv_en_w;

  assign send_en_w = (mode_w == LM_SEND);
  assign recv_en_w = (mode_w == LM_RECV);
  assign mode_o    = mode_w;

  coil_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .tx_moving (tx_busy_w || tx_accept_w),
    .rx_moving (rx_mid_w),
    .mode_q    (mode_w)
  );

  coil_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_mode   (send_en_w),
    .word_tick (word_tick),
    .tx_valid  (tx_valid),
    .tx_word   (tx_word),
    .tx_ready  (tx_ready),
    .ser_dat   (link_dat_o),
    .ser_stb   (link_stb_o),
    .busy      (tx_busy_w),
    .accept    (tx_accept_w)
  );

  coil_rx_deshift #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_mode   (recv_en_w),
    .ser_dat   (link_dat_i),
    .ser_stb   (link_stb_i),
    .word_tick (word_tick),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word),
    .rx_ovf    (rx_ovf),
    .moving    (rx_mid_w),
    .done      (rx_done_w)
  );

endmodule

// File: rtl/coil_link_chk.sv
module coil_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [1:0] mode_o,
  input logic       word_tick,
  input logic       link_stb_o,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_ovf,
  input logic       tx_busy,
  input logic       rx_done
);

  // R1
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |=> mode_o == $past(mode_o));

  // R3
  tx_hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> mode_o == $past(mode_o));

  // R6
  stb_only_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && $past(mode_o) == 2'b01 && link_stb_o != $past(link_stb_o)) |-> tx_busy);

  // R10
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid);

  // R10
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !word_tick && !rx_done) |=> rx_valid);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);

endmodule

bind coil_link_top coil_link_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .mode_o     (mode_o),
  .word_tick  (word_tick),
  .link_stb_o (link_stb_o),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_ovf     (rx_ovf),
  .tx_busy    (tx_busy_w),
  .rx_done    (rx_done_w)
);

// File: tb/coil_link_top_test.sv
module coil_link_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 35;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic [1:0]    mode_o;
  logic          word_tick = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [W-1:0]  tx_word = '0;
  logic          link_dat_o, link_stb_o;
  logic          link_dat_i = 1'b0, link_stb_i = 1'b0;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [W-1:0]  rx_word;
  logic          rx_ovf;

  int vectors = 0;
  int misses  = 0;
  int tcnt    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coil_link_top uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_o(mode_o),
    .word_tick(word_tick), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word),
    .link_dat_o(link_dat_o), .link_stb_o(link_stb_o),
    .link_dat_i(link_dat_i), .link_stb_i(link_stb_i),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word), .rx_ovf(rx_ovf)
  );

  // Word-rate pulse, one cycle in forty
  always @(negedge clk) begin
    word_tick <= (tcnt == 0);
    tcnt <= (tcnt == 39) ? 0 : tcnt + 1;
  end

  // Behavioural reference model
  int           m_mode, m_sent, m_rn;
  logic         m_fly, m_dat, m_stb, m_prev, m_pend, m_win, m_ovf;
  logic [W-1:0] m_txw, m_acc, m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_sent = 0; m_rn = 0;
      m_fly = 0; m_dat = 0; m_stb = 0; m_prev = 0;
      m_pend = 0; m_win = 0; m_ovf = 0;
      m_txw = '0; m_acc = '0; m_word = '0;
    end else begin
      logic acc, redge, take, hold;
      int   old_mode;
      acc      = word_tick && tx_valid && m_mode == 1 && !m_fly;
      redge    = m_mode == 2 && (link_stb_i != m_prev);
      take     = m_pend && m_win && rx_ready;
      hold     = m_fly || acc || m_rn != 0 || redge;
      old_mode = m_mode;
      if (old_mode != 1) begin
        m_dat = 0; m_stb = 0; m_fly = 0; m_sent = 0;
      end else if (acc) begin
        m_txw = tx_word; m_dat = tx_word[0]; m_stb = !m_stb; m_fly = 1; m_sent = 1;
      end else if (m_fly) begin
        if (m_sent == W) begin
          m_fly = 0; m_dat = 0; m_sent = 0;
        end else begin
          m_dat = m_txw[m_sent]; m_stb = !m_stb; m_sent++;
        end
      end
      if (redge) begin
        m_acc[m_rn] = link_dat_i;
        m_rn++;
      end
      if (redge && m_rn == W) begin
        m_word = m_acc;
        if (m_pend && !take) m_ovf = 1;
        m_pend = 1; m_win = 1; m_rn = 0;
      end else begin
        if (take) m_pend = 0;
        if (word_tick && m_win) m_win = 0;
      end
      m_prev = link_stb_i;
      if (!hold && mode_sel != 2'b11) m_mode = int'(mode_sel);
    end
  end

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, a little after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic ev;
      vectors++;
      ev = m_pend && m_win;
      cmp("R2 mode_o", W'(mode_o), W'(m_mode));
      cmp("R4 tx_ready", W'(tx_ready), W'(word_tick && m_mode == 1 && !m_fly));
      cmp("R5 link_dat_o", W'(link_dat_o), W'(m_mode == 1 && m_dat));
      cmp("R6 link_stb_o", W'(link_stb_o), W'(m_mode == 1 && m_stb));
      cmp("R10 rx_valid", W'(rx_valid), W'(ev));
      if (ev) cmp("R8 rx_word", rx_word, m_word);
      cmp("R11 rx_ovf", W'(rx_ovf), W'(m_ovf));
    end
  end

  task automatic directed(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    cmp(tag, act, exp);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    tx_word  = w;
    tx_valid = 1'b1;
    #2;
    while (!tx_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_feed(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      link_dat_i = w[i];
      link_stb_i = ~link_stb_i;
    end
    @(negedge clk);
    link_dat_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic finished = 1'b0;

  initial begin
    idle_cycles(3);
    #2;
    // R7: outputs are low in the reset state
    directed("R7 reset mode", W'(mode_o), W'(0));
    directed("R7 reset dat", W'(link_dat_o), W'(0));
    directed("R7 reset stb", W'(link_stb_o), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(2);

    // R2: send mode visible one cycle after request
    mode_sel = 2'b01;
    @(negedge clk); #2;
    directed("R2 mode to send", W'(mode_o), W'(1));

    // R5/R6: word in flight; R3: request held back
    send_word(35'h4_DEAD_BEEF);
    idle_cycles(4);
    mode_sel = 2'b10;
    idle_cycles(2); #2;
    directed("R3 deferred switch", W'(mode_o), W'(1));
    idle_cycles(40); #2;
    directed("R3 switch after word", W'(mode_o), W'(2));
    directed("R7 recv dat", W'(link_dat_o), W'(0));

    // R1: illegal code ignored
    mode_sel = 2'b11;
    idle_cycles(3); #2;
    directed("R1 code 11 ignored", W'(mode_o), W'(2));

    // R8: receive and take
    rx_ready = 1'b1;
    rx_feed(35'h2_1234_5678);
    idle_cycles(4);

    // R11: two words, none taken
    rx_ready = 1'b0;
    rx_feed(35'h7_0F0F_0F0F);
    rx_feed(35'h0_AAAA_5555);
    idle_cycles(2); #2;
    directed("R11 overflow set", W'(rx_ovf), W'(1));
    rx_ready = 1'b1;
    idle_cycles(45);

    // R9: strobe toggles in idle must not misalign the next word
    mode_sel = 2'b00;
    idle_cycles(2);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      link_stb_i = ~link_stb_i;
      link_dat_i = k[0];
    end
    @(negedge clk);
    mode_sel = 2'b10;
    idle_cycles(2);
    rx_ready = 1'b0;
    rx_feed(35'h5_CAFE_0001);
    #2;
    directed("R9 word after idle", rx_word, 35'h5_CAFE_0001);
    directed("R9 valid after idle", W'(rx_valid), W'(1));
    rx_ready = 1'b1;
    idle_cycles(45);

    // R4/R5/R6: more send patterns
    mode_sel = 2'b01;
    idle_cycles(2);
    send_word('1);
    send_word(35'h2_AAAA_AAAA);
    send_word(35'h0_0000_0001);
    idle_cycles(45);
    mode_sel = 2'b00;
    idle_cycles(3); #2;
    directed("R7 idle stb", W'(link_stb_o), W'(0));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule